// File: doc/BRIEF.md
# Self-Timed Page Write and Protection Sequencer

This block sits behind the serial front end of a word-organised nonvolatile memory. The front end has already found the start bit and the opcode. It hands this block a command pulse carrying an operation code and an address. For write operations it then hands over one pulse per received data word. The block gathers up to four words in a small page buffer and watches chip select in the one clock after the last word. It checks every target address against a protection boundary. If the command is accepted, it runs a self-timed programming cycle on a word-wide memory write port. The cycle first writes one word per clock and then counts a fixed programming time.

While a cycle runs, the block reports its progress on a serial status output whenever chip select is high. It also holds the write-enable latch and the protection boundary. The boundary has a cleared state and a lock bit. Once the lock bit is set, the boundary never changes again.

The sequencer has six states. Each transition is named here.

- **IDLE** moves to **LOAD** on an accepted write command (*take*). It moves to **DRAIN** on a write command that is not permitted (*refuse*).
- **LOAD** moves to **WIN** when a word arrives (*push*). It returns to IDLE when chip select falls (*early drop*). It moves to DRAIN when the write-enable pin falls (*pin loss*).
- **WIN** moves to **PROG** when chip select is low and the targets are allowed (*commit*). It returns to IDLE when chip select is low and a target is guarded (*reject*). It moves back to LOAD when chip select stays high on a page with room left (*more*). Otherwise it moves to DRAIN (*late*).
- **DRAIN** returns to IDLE once chip select is low (*release*).
- **PROG** moves to **HOLD** after its last word (*written*).
- **HOLD** returns to IDLE when the programming time has been counted (*done*).

Top module: `page_prog_seq`

## Requirements
- R1: After reset the block is in IDLE, `mem_we` and `sdo_oe` are low, the write-enable latch is off, the boundary is in its cleared state, and the boundary is unlocked.
- R2: A write command (op 0 word, 1 page, 2 all) is taken only if the write-enable latch is on and `we_pin` is high at the command. The latch is set by op 3 and cleared by op 4. `we_pin` must also stay high until the commit, or no cycle starts.
- R3: A cycle starts only if `cs` is low at the first clock after the clock that accepted the last word. If `cs` drops before that word, or is still high at that clock, the command is dropped without any memory write.
- R4: A page write (op 1) accepts one to four words. Word i goes to the address whose upper bits equal the start address and whose two low bits equal (start + i) mod 4.
- R5: An address is guarded when the boundary is not cleared and the address is greater than or equal to the boundary. A word or page write is rejected as a whole if any of its target addresses is guarded.
- R6: A write-all (op 2) is accepted only while the boundary is cleared. It writes its single word to every location 0 to DEPTH-1.
- R7: An accepted cycle asserts `mem_we` for one clock per word, N clocks in all (N = word count, or DEPTH for write-all). It then counts PROG_CYCLES clocks, so the cycle is busy for N + PROG_CYCLES clocks after the commit clock.
- R8: During a cycle the status is driven once `cs` has been high for SEL_DLY clocks. `sdo` is low while busy. After the cycle ends, `sdo` is high and stays high until `cs` falls or a new command pulse is seen.
- R9: Command and word pulses received during a cycle have no effect.
- R10: Op 5 loads the boundary from `cmd_addr`, op 6 clears it, and op 7 sets the lock. Each needs the latch on and `we_pin` high. Once the lock is set, ops 5, 6 and 7 leave the boundary unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select level from the serial pins |
| we_pin | input | 1 | External write-enable pin |
| cmd_valid | input | 1 | One-clock pulse for a decoded command |
| cmd_op | input | 3 | Operation code (see R2, R10) |
| cmd_addr | input | ADDR_W | Start address, or the boundary value for op 5 |
| word_valid | input | 1 | One-clock pulse for a received data word |
| word_data | input | DATA_W | Received data word |
| mem_we | output | 1 | Memory array write strobe |
| mem_addr | output | ADDR_W | Memory array write address |
| mem_wdata | output | DATA_W | Memory array write data |
| sdo | output | 1 | Status bit: 0 busy, 1 ready |
| sdo_oe | output | 1 | Status output drive enable |

## Verification
The commit is decided at the first clock after the last word. From there, the bench raises `cs` and counts rising edges. It expects the busy level on the SEL_DLY-th edge and the ready level on exactly edge N + PROG_CYCLES. That is 1 to 4 + 16 for word and page writes, and 16 + 16 for write-all in the 16-word bench configuration. Memory contents are compared only after the ready level has been seen, so every write of the cycle has landed. Rejected and cancelled commands are checked by keeping `cs` high for SEL_DLY + 3 clocks with no status drive, and then comparing the whole array with the model.

// File: rtl/pps_pkg.sv
package pps_pkg;
    typedef enum logic [2:0] {
        OP_WORD  = 3'd0,
        OP_PAGE  = 3'd1,
        OP_ALL   = 3'd2,
        OP_WREN  = 3'd3,
        OP_WRDIS = 3'd4,
        OP_BOUND = 3'd5,
        OP_BCLR  = 3'd6,
        OP_BLOCK = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_WIN,
        S_DRAIN,
        S_PROG,
        S_HOLD
    } st_e;

    localparam int PAGE_WORDS = 4;
    localparam int CNT_W      = $clog2(PAGE_WORDS + 1);
endpackage

// File: rtl/pps_pagebuf.sv
module pps_pagebuf import pps_pkg::*; #(
    parameter int DATA_W = 16
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  clear,
    input  logic                                  push,
    input  logic [DATA_W-1:0]                     din,
    output logic [PAGE_WORDS-1:0][DATA_W-1:0]     words,
    output logic [CNT_W-1:0]                      cnt
);
    logic full;
    assign full = (cnt == CNT_W'(PAGE_WORDS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt <= '0;
        else if (clear)           cnt <= '0;
        else if (push && !full)   cnt <= cnt + 1'b1;
    end

    for (genvar g = 0; g < PAGE_WORDS; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                words[g] <= '0;
            else if (push && !full && !clear && cnt == CNT_W'(g))
                words[g] <= din;
        end
    end
endmodule

// File: rtl/pps_guard.sv
module pps_guard #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_req,
    input  logic              clr_req,
    input  logic              lock_req,
    input  logic [ADDR_W-1:0] bound_in,
    output logic [ADDR_W-1:0] bound_q,
    output logic              clr_q,
    output logic              lock_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bound_q <= '0;
            clr_q   <= 1'b1;
            lock_q  <= 1'b0;
        end else if (!lock_q) begin
            if (set_req) begin
                bound_q <= bound_in;
                clr_q   <= 1'b0;
            end else if (clr_req) begin
                clr_q   <= 1'b1;
            end else if (lock_req) begin
                lock_q  <= 1'b1;
            end
        end
    end

    // R10: the lock never falls and the boundary is frozen behind it
    assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);
    assert_lock_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> ($stable(bound_q) && $stable(clr_q)));
endmodule

// File: rtl/pps_status.sv
module pps_status #(
    parameter int SEL_DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic busy,
    input  logic cyc_start,
    input  logic cmd_valid,
    output logic sdo,
    output logic sdo_oe
);
    localparam int SCW = $clog2(SEL_DLY + 2);

    logic [SCW-1:0] sel_cnt;
    logic           armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         sel_cnt <= '0;
        else if (!cs)                       sel_cnt <= '0;
        else if (sel_cnt != SCW'(SEL_DLY))  sel_cnt <= sel_cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           armed <= 1'b0;
        else if (cyc_start)                   armed <= 1'b1;
        else if (!busy && (!cs || cmd_valid)) armed <= 1'b0;
    end

    assign sdo_oe = armed && cs && (sel_cnt == SCW'(SEL_DLY));
    assign sdo    = sdo_oe && !busy;

    // R8: a shown ready level persists while select stays high and no command arrives
    assert_ready_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && sdo && !cmd_valid) |=> ((sdo_oe && sdo) || !cs));
endmodule

// File: rtl/page_prog_seq.sv
module page_prog_seq import pps_pkg::*; #(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 16,
    parameter int SEL_DLY     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              we_pin,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              word_valid,
    input  logic [DATA_W-1:0] word_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              sdo,
    output logic              sdo_oe
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int HCW   = $clog2(PROG_CYCLES + 1);

    st_e                              state, nxt;
    op_e                              op_q, op_in;
    logic [ADDR_W-1:0]                base_q, idx_q, last_idx;
    logic [HCW-1:0]                   hold_q;
    logic                             wen_q;
    logic [PAGE_WORDS-1:0][DATA_W-1:0] words;
    logic [CNT_W-1:0]                 cnt;
    logic [ADDR_W-1:0]                bound_q;
    logic                             clr_q, lock_q;
    logic [PAGE_WORDS-1:0]            hit;
    logic                             cmd_take, is_wr, may_write, accept_ok;
    logic                             push, busy, cyc_start;
    logic                             set_req, clr_req, lock_req;

    function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] b,
                                                   input logic [1:0] i);
        return {b[ADDR_W-1:2], 2'(b[1:0] + i)};
    endfunction

    function automatic logic guarded(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] bnd,
                                     input logic clr);
        return !clr && (a >= bnd);
    endfunction

    assign op_in     = op_e'(cmd_op);
    assign cmd_take  = (state == S_IDLE) && cmd_valid && cs;
    assign is_wr     = (op_in == OP_WORD) || (op_in == OP_PAGE) || (op_in == OP_ALL);
    assign may_write = wen_q && we_pin;

    for (genvar g = 0; g < PAGE_WORDS; g++) begin : g_hit
        assign hit[g] = (CNT_W'(g) < cnt) &&
                        guarded(slot_addr(base_q, 2'(g)), bound_q, clr_q);
    end

    assign accept_ok = (op_q == OP_ALL) ? clr_q : ~|hit;
    assign last_idx  = (op_q == OP_ALL) ? ADDR_W'(DEPTH - 1)
                                        : ADDR_W'(2'(cnt - 1'b1));

    pps_pagebuf #(.DATA_W(DATA_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .clear(cmd_take), .push(push),
        .din(word_data), .words(words), .cnt(cnt)
    );

    pps_guard #(.ADDR_W(ADDR_W)) u_guard (
        .clk(clk), .rst_n(rst_n), .set_req(set_req), .clr_req(clr_req),
        .lock_req(lock_req), .bound_in(cmd_addr), .bound_q(bound_q),
        .clr_q(clr_q), .lock_q(lock_q)
    );

    pps_status #(.SEL_DLY(SEL_DLY)) u_stat (
        .clk(clk), .rst_n(rst_n), .cs(cs), .busy(busy), .cyc_start(cyc_start),
        .cmd_valid(cmd_valid), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (cmd_take && is_wr) nxt = may_write ? S_LOAD : S_DRAIN;
            S_LOAD:  if (!we_pin)           nxt = S_DRAIN;
                     else if (!cs)          nxt = S_IDLE;
                     else if (word_valid)   nxt = S_WIN;
            S_WIN:   if (!cs)               nxt = (we_pin && accept_ok) ? S_PROG : S_IDLE;
                     else if (op_q == OP_PAGE && cnt != CNT_W'(PAGE_WORDS) && we_pin)
                                            nxt = S_LOAD;
                     else                   nxt = S_DRAIN;
            S_DRAIN: if (!cs)               nxt = S_IDLE;
            S_PROG:  if (idx_q == last_idx) nxt = S_HOLD;
            S_HOLD:  if (hold_q == HCW'(PROG_CYCLES - 1)) nxt = S_IDLE;
            default:                        nxt = S_IDLE;
        endcase
    end

    // state register and sequencing registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            op_q   <= OP_WORD;
            base_q <= '0;
            idx_q  <= '0;
            hold_q <= '0;
            wen_q  <= 1'b0;
        end else begin
            state <= nxt;
            if (cmd_take) begin
                op_q   <= op_in;
                base_q <= cmd_addr;
                if (op_in == OP_WREN)  wen_q <= 1'b1;
                if (op_in == OP_WRDIS) wen_q <= 1'b0;
            end
            if (cyc_start)             idx_q  <= '0;
            else if (state == S_PROG)  idx_q  <= idx_q + 1'b1;
            if (state == S_PROG)       hold_q <= '0;
            else if (state == S_HOLD)  hold_q <= hold_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy      = (state == S_PROG) || (state == S_HOLD);
        cyc_start = (state == S_WIN) && (nxt == S_PROG);
        push      = (state == S_LOAD) && we_pin && cs && word_valid;
        set_req   = cmd_take && may_write && (op_in == OP_BOUND);
        clr_req   = cmd_take && may_write && (op_in == OP_BCLR);
        lock_req  = cmd_take && may_write && (op_in == OP_BLOCK);
        mem_we    = (state == S_PROG);
        mem_addr  = (op_q == OP_ALL) ? idx_q : slot_addr(base_q, idx_q[1:0]);
        mem_wdata = (op_q == OP_ALL) ? words[0] : words[idx_q[1:0]];
    end

    // R3: a cycle begins only out of the window state with select low
    assert_commit_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(state) == S_WIN && !$past(cs)));
    // R5: no guarded location is ever written by a word or page cycle
    assert_write_unguarded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && op_q != OP_ALL) |-> !guarded(mem_addr, bound_q, clr_q));
    // R6: write-all strobes only while the boundary is cleared
    assert_all_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && op_q == OP_ALL) |-> clr_q);
    // R7: a busy cycle ends only by returning to IDLE
    assert_busy_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || state == S_IDLE));
endmodule

// File: tb/sim_page_prog_seq.sv
`timescale 1ns/1ps
module sim_page_prog_seq;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam int PC = 16;
    localparam int SD = 2;
    localparam int DEP = 1 << AW;

    logic clk = 0, rst_n = 0, cs = 0, we_pin = 1, cmd_valid = 0, word_valid = 0;
    logic [2:0] cmd_op = 0;
    logic [AW-1:0] cmd_addr = 0;
    logic [DW-1:0] word_data = 0;
    logic mem_we, sdo, sdo_oe;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;

    logic [DW-1:0] mem [DEP];
    logic [DW-1:0] exp_mem [DEP];
    logic [DW-1:0] wbuf [4];
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    page_prog_seq #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PC), .SEL_DLY(SD)) u0 (
        .clk(clk), .rst_n(rst_n), .cs(cs), .we_pin(we_pin), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .word_valid(word_valid),
        .word_data(word_data), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEP; i++) mem[i] <= '0;
        end else if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    function automatic logic [DW-1:0] pat(input int a, input int s);
        return DW'((a * 16'h1357) ^ (s << 8) ^ 16'h0F0F);
    endfunction

    task automatic cmp_mem(input string req);
        int bad = 0;
        int first = -1;
        for (int i = 0; i < DEP; i++)
            if (mem[i] !== exp_mem[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        chk(bad == 0, req, "memory mismatches", bad, 0);
        if (bad != 0)
            $display("  first bad addr %0d: actual %h expected %h", first, mem[first], exp_mem[first]);
    endtask

    task automatic simple_cmd(input logic [2:0] op, input logic [AW-1:0] a);
        @(negedge clk); cs = 1; cmd_valid = 1; cmd_op = op; cmd_addr = a;
        @(negedge clk); cmd_valid = 0; cs = 0;
        @(negedge clk);
    endtask

    // full write transaction with commit in the window; poke=1 sends traffic mid-cycle
    task automatic run_cmd(input logic [2:0] op, input logic [AW-1:0] a, input int n,
                           input bit ok, input bit poke, input string req);
        int len;
        int k;
        @(negedge clk); cs = 1; cmd_valid = 1; cmd_op = op; cmd_addr = a;
        @(negedge clk); cmd_valid = 0;
        for (int i = 0; i < n; i++) begin
            word_valid = 1; word_data = wbuf[i];
            @(negedge clk); word_valid = 0;
            if (i < n - 1) @(negedge clk);
        end
        cs = 0;
        @(negedge clk); cs = 1;
        if (!ok) begin
            repeat (SD + 3) @(negedge clk);
            chk(!sdo_oe, req, "rejected command drives status", int'(sdo_oe), 0);
        end else begin
            len = (op == 3'd2) ? DEP + PC : n + PC;
            k = 0;
            forever begin
                @(negedge clk); k++;
                if (poke && k == 3) begin
                    cmd_valid = 1; cmd_op = 3'd4; word_valid = 1; word_data = 16'hDEAD;
                end
                if (poke && k == 4) begin
                    cmd_valid = 0; word_valid = 0;
                end
                if (k == SD)
                    chk(sdo_oe && !sdo, "R8", "busy level", int'({sdo_oe, sdo}), 2);
                if ((sdo_oe && sdo) || k > 300) break;
            end
            chk(k == len, "R7", "cycle length", k, len);
            if (op == 3'd2) begin
                for (int i = 0; i < DEP; i++) exp_mem[i] = wbuf[0];
            end else begin
                for (int i = 0; i < n; i++)
                    exp_mem[{a[AW-1:2], 2'(a[1:0] + 2'(i))}] = wbuf[i];
            end
            @(negedge clk);
            chk(sdo_oe && sdo, "R8", "ready level held", int'({sdo_oe, sdo}), 3);
        end
        cs = 0;
        @(negedge clk);
        chk(!sdo_oe, "R8", "status off after deselect", int'(sdo_oe), 0);
        cmp_mem(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        for (int i = 0; i < DEP; i++) exp_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(!mem_we && !sdo_oe, "R1", "outputs idle after reset", int'({mem_we, sdo_oe}), 0);
        cs = 1; repeat (SD + 2) @(negedge clk);
        chk(!sdo_oe, "R1", "no status with select high after reset", int'(sdo_oe), 0);
        cs = 0; @(negedge clk);

        // R1/R2: latch off after reset, word write refused
        wbuf[0] = 16'h1111;
        run_cmd(3'd0, 4'd3, 1, 0, 0, "R1");

        // R1/R6: boundary cleared after reset, write-all accepted
        simple_cmd(3'd3, '0);
        wbuf[0] = 16'hA5A5;
        run_cmd(3'd2, '0, 1, 1, 0, "R6");

        // R4/R7: exhaustive word write sweep
        for (int a = 0; a < DEP; a++) begin
            wbuf[0] = pat(a, 1);
            run_cmd(3'd0, AW'(a), 1, 1, 0, "R4");
        end

        // R4: page sweep over every start address, counts 1..4 with wraps
        for (int a = 0; a < DEP; a++) begin
            int n = ((a * 3) % 4) + 1;
            for (int i = 0; i < 4; i++) wbuf[i] = pat(a + i, 2);
            run_cmd(3'd1, AW'(a), n, 1, 0, "R4");
        end

        // R3: late deselect cancels
        @(negedge clk); cs = 1; cmd_valid = 1; cmd_op = 3'd0; cmd_addr = 4'd5;
        @(negedge clk); cmd_valid = 0; word_valid = 1; word_data = 16'hBEEF;
        @(negedge clk); word_valid = 0;
        @(negedge clk); cs = 0;
        @(negedge clk); cs = 1;
        repeat (SD + 3) @(negedge clk);
        chk(!sdo_oe, "R3", "late deselect starts no cycle", int'(sdo_oe), 0);
        cs = 0; @(negedge clk);
        cmp_mem("R3");

        // R3: early deselect cancels, later word ignored
        @(negedge clk); cs = 1; cmd_valid = 1; cmd_op = 3'd0; cmd_addr = 4'd6;
        @(negedge clk); cmd_valid = 0; cs = 0;
        @(negedge clk); word_valid = 1; word_data = 16'hCAFE;
        @(negedge clk); word_valid = 0;
        @(negedge clk); cs = 1;
        repeat (SD + 3) @(negedge clk);
        chk(!sdo_oe, "R3", "early deselect starts no cycle", int'(sdo_oe), 0);
        cs = 0; @(negedge clk);
        cmp_mem("R3");

        // R2: pin low at command
        we_pin = 0;
        wbuf[0] = 16'h7777;
        run_cmd(3'd0, 4'd2, 1, 0, 0, "R2");
        we_pin = 1;

        // R2: pin dropped mid page
        @(negedge clk); cs = 1; cmd_valid = 1; cmd_op = 3'd1; cmd_addr = 4'd8;
        @(negedge clk); cmd_valid = 0; word_valid = 1; word_data = 16'h0101;
        @(negedge clk); word_valid = 0; we_pin = 0;
        @(negedge clk); word_valid = 1; word_data = 16'h0202;
        @(negedge clk); word_valid = 0; cs = 0;
        @(negedge clk); cs = 1; we_pin = 1;
        repeat (SD + 3) @(negedge clk);
        chk(!sdo_oe, "R2", "pin loss starts no cycle", int'(sdo_oe), 0);
        cs = 0; @(negedge clk);
        cmp_mem("R2");

        // R9: traffic during a cycle ignored (WRDIS mid-cycle has no effect)
        wbuf[0] = 16'h9999;
        run_cmd(3'd0, 4'd1, 1, 1, 1, "R9");
        wbuf[0] = 16'h9A9A;
        run_cmd(3'd0, 4'd2, 1, 1, 0, "R9");

        // R5: boundary 8, word sweep accepted iff address below 8
        simple_cmd(3'd5, 4'd8);
        for (int a = 0; a < DEP; a++) begin
            wbuf[0] = pat(a, 3);
            run_cmd(3'd0, AW'(a), 1, a < 8, 0, "R5");
        end
        for (int i = 0; i < 4; i++) wbuf[i] = pat(i, 4);
        run_cmd(3'd1, 4'd7, 4, 1, 0, "R5");
        run_cmd(3'd1, 4'd10, 2, 0, 0, "R5");
        run_cmd(3'd1, 4'd14, 3, 0, 0, "R5");
        // R6: write-all refused while boundary set
        wbuf[0] = 16'h5555;
        run_cmd(3'd2, '0, 1, 0, 0, "R6");
        // R6: cleared again, accepted
        simple_cmd(3'd6, '0);
        wbuf[0] = 16'h3C3C;
        run_cmd(3'd2, '0, 1, 1, 0, "R6");

        // R10: lock freezes boundary 12
        simple_cmd(3'd5, 4'd12);
        simple_cmd(3'd7, '0);
        simple_cmd(3'd6, '0);
        simple_cmd(3'd5, 4'd4);
        wbuf[0] = 16'h4444;
        run_cmd(3'd2, '0, 1, 0, 0, "R10");
        wbuf[0] = 16'h6666;
        run_cmd(3'd0, 4'd6, 1, 1, 0, "R10");
        wbuf[0] = 16'hDDDD;
        run_cmd(3'd0, 4'd13, 1, 0, 0, "R10");

        // R8: ready cleared by a new command pulse while select stays high
        wbuf[0] = 16'h1234;
        run_cmd(3'd0, 4'd0, 1, 1, 0, "R8");
        @(negedge clk); cs = 1; cmd_valid = 1; cmd_op = 3'd4;
        @(negedge clk); cmd_valid = 0;
        repeat (SD + 2) @(negedge clk);
        chk(!sdo_oe, "R8", "no status when no cycle ran", int'(sdo_oe), 0);
        cs = 0; @(negedge clk);

        // R2: latch cleared by op 4, write refused
        wbuf[0] = 16'hEEEE;
        run_cmd(3'd0, 4'd3, 1, 0, 0, "R2");

        report();
    end
endmodule